// File: doc/BRIEF.md
# Linked-List Descriptor Autoload DMA Sequencer

This block steers a single DMA logical channel through a chain of descriptors that sit in memory. Every descriptor carries fresh values for part or all of the channel configuration. The sequencer reads a descriptor one word at a time over a word-read port and writes the payload words into the channel configuration registers. It then starts a transfer on an external transfer datapath through a start/done handshake. When that transfer finishes it moves to the next descriptor. No processor action is needed between elements.

Software programs the configuration registers directly while the channel is idle. It picks linked-list mode and fast or non-fast first-load ordering, gives the address of the first descriptor and issues a start. In non-fast mode the channel first runs one transfer with the values it already holds and only then walks the chain. In fast mode it loads the first descriptor before any transfer. A descriptor can request a halt after its load, and the channel then waits for a resume command. One interrupt pulse marks the end of the whole chain, and a sticky copy of it stays set until software clears it.

Top module: `lldma_seq`

## Requirements
- R1: `sts_state` reports 0 idle, 1 loading, 2 transferring, 3 paused, 4 done. A start is accepted only in idle or done. A start in any other state changes neither the state nor `sts_cur_desc`.
- R2: With list mode on and fast mode off, a start leads to state 2 on the next cycle, with no descriptor read. That transfer uses the configuration already held. The descriptor at the head address is read only after `xfer_done`.
- R3: With list mode and fast mode both on, a start leads to state 1. The head descriptor is fully loaded before the first `xfer_start`, and the first transfer uses the loaded values.
- R4: A descriptor begins with a header word. Bits [1:0] give the format (1, 2 or 3), bit 2 requests a pause and bit 3 marks the end of the chain. The next word is the address of the next descriptor. Payload words follow in the fixed field order src, dst, elem, frame, ctrl, stride. Format 1 has 6 payload words, format 2 has 3 and format 3 has 2. Format 0 has none.
- R5: A configuration field that the descriptor's format does not cover keeps its earlier value.
- R6: A loaded descriptor with the pause bit set puts the channel in state 3 without a transfer start. It stays there until `ctl_resume`, which starts the transfer. A resume in any other state has no effect.
- R7: A transfer in progress cannot be interrupted. State 2 is left only on `xfer_done`. The configuration outputs stay constant during a transfer, and `prog_we` is ignored outside idle and done.
- R8: In list mode, each completed transfer is followed by loading the next descriptor and starting its transfer, until the descriptor with the end flag has been transferred. With list mode off, a start runs exactly one transfer and reads no memory.
- R9: `irq` is a one-cycle pulse, raised once per run, in the cycle the channel enters state 4 after its final transfer. It also sets `sts_irq_sticky`, which is cleared by a 1 on `ctl_irq_clr`.
- R10: The read port has at most one request outstanding. Requests are issued only in state 1, and they address the descriptor base plus the word index, in increasing order.
- R11: `sts_cur_desc` holds the address of the descriptor that is being loaded or was loaded last.
- R12: `xfer_start` is a one-cycle pulse, given once per transfer, in the first cycle of state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Start command pulse |
| ctl_resume | input | 1 | Resume a paused channel |
| ctl_fast | input | 1 | Fast first-load ordering, sampled at start |
| ctl_list_en | input | 1 | Linked-list mode enable, sampled at start |
| ctl_head | input | AW | Address of first descriptor, sampled at start |
| ctl_irq_clr | input | 1 | Write-one clear of the sticky interrupt bit |
| prog_we | input | 1 | Direct configuration write strobe |
| prog_idx | input | 3 | Field index for the direct write (0 src .. 5 stride) |
| prog_data | input | DW | Direct write data |
| sts_state | output | 3 | Channel state code |
| sts_cur_desc | output | AW | Address of current descriptor |
| sts_irq_sticky | output | 1 | Sticky completion flag |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Word read request accepted |
| rd_req_addr | output | AW | Word read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Read data |
| xfer_start | output | 1 | Start pulse to transfer datapath |
| xfer_done | input | 1 | Transfer finished pulse |
| cfg_src | output | DW | Source address field |
| cfg_dst | output | DW | Destination address field |
| cfg_elem | output | DW | Element count field |
| cfg_frame | output | DW | Frame count field |
| cfg_ctrl | output | DW | Control field |
| cfg_stride | output | DW | Stride field |
| irq | output | 1 | Chain completion pulse |

## Verification
The hardest situation to reach is a command that lands in the wrong phase: a start or a direct write arriving mid-transfer, or a resume sent while no pause is pending. The bench keeps a memory responder with a stalling ready pattern and a transfer responder with a fixed length, so it knows how long each transfer lasts. It waits until the state code shows a transfer under way and then injects these commands inside that window. The reference queue of expected configurations then shows whether any extra transfer or field change slipped through. A chain that ends in a pausing format-1 descriptor, started in fast mode, holds the channel in the paused state. There the bench checks that no transfer start appears before the resume.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int WIDX_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_PAUSE = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    // header word layout, low nibble
    typedef struct packed {
        logic       eol;
        logic       pause;
        logic [1:0] kind;
    } desc_hdr_t;

    function automatic logic [WIDX_W-1:0] payload_words(input logic [1:0] kind);
        case (kind)
            2'd1:    return 3'd6;
            2'd2:    return 3'd3;
            2'd3:    return 3'd2;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/lldma_fetch.sv
module lldma_fetch
    import lldma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [AW-1:0]     go_addr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_data,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_idx,
    output logic [DW-1:0]     wr_data,
    output logic              load_done,
    output logic              hdr_pause,
    output logic              hdr_eol,
    output logic [AW-1:0]     next_ptr
);

    logic              busy_q, pend_q;
    logic [WIDX_W-1:0] widx_q, last_q;
    logic [AW-1:0]     base_q, next_q;
    desc_hdr_t         hdr_q;
    desc_hdr_t         hdr_in;
    logic              rsp_fire, is_last;

    assign hdr_in    = desc_hdr_t'(rsp_data[3:0]);
    assign rsp_fire  = busy_q && pend_q && rsp_valid;
    assign is_last   = (widx_q != '0) && (widx_q == last_q);
    assign req_valid = busy_q && !pend_q;
    assign req_addr  = base_q + AW'(widx_q);

    assign wr_en     = rsp_fire && (widx_q >= 3'd2);
    assign wr_idx    = widx_q - 3'd2;
    assign wr_data   = rsp_data;
    assign load_done = rsp_fire && is_last;
    assign hdr_pause = hdr_q.pause;
    assign hdr_eol   = hdr_q.eol;
    assign next_ptr  = next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            widx_q <= '0;
            last_q <= '1;
            base_q <= '0;
            next_q <= '0;
            hdr_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            pend_q <= 1'b0;
            widx_q <= '0;
            last_q <= '1;
            base_q <= go_addr;
        end else if (busy_q) begin
            if (req_valid && req_ready) begin
                pend_q <= 1'b1;
            end
            if (rsp_fire) begin
                pend_q <= 1'b0;
                if (widx_q == 3'd0) begin
                    hdr_q  <= hdr_in;
                    last_q <= 3'd1 + payload_words(hdr_in.kind);
                end
                if (widx_q == 3'd1) begin
                    next_q <= rsp_data[AW-1:0];
                end
                if (is_last) begin
                    busy_q <= 1'b0;
                end else begin
                    widx_q <= widx_q + 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/lldma_cfg_regs.sv
module lldma_cfg_regs
    import lldma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             prog_we,
    input  logic [WIDX_W-1:0]                prog_idx,
    input  logic [DW-1:0]                    prog_data,
    input  logic                             load_we,
    input  logic [WIDX_W-1:0]                load_idx,
    input  logic [DW-1:0]                    load_data,
    output logic [NUM_FIELDS-1:0][DW-1:0]    fields
);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        logic [DW-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (load_we && (load_idx == WIDX_W'(f))) begin
                val_q <= load_data;
            end else if (prog_we && (prog_idx == WIDX_W'(f))) begin
                val_q <= prog_data;
            end
        end
        assign fields[f] = val_q;
    end

endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
    import lldma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          resume,
    input  logic          fast,
    input  logic          list_en,
    input  logic [AW-1:0] head,
    input  logic          irq_clr,
    input  logic          xfer_done,
    input  logic          load_done,
    input  logic          hdr_pause,
    input  logic          hdr_eol,
    input  logic [AW-1:0] next_ptr,
    output logic          fetch_go,
    output logic [AW-1:0] fetch_addr,
    output logic          xfer_start,
    output seq_state_e    state,
    output logic [AW-1:0] cur_desc,
    output logic          prog_ok,
    output logic          irq,
    output logic          irq_sticky
);

    seq_state_e    st_q, st_d;
    logic          list_q, have_q, xs_q, irq_q, sticky_q;
    logic [AW-1:0] head_q, cur_q;
    logic          enter_x, accept, finish;

    always_comb begin
        st_d       = st_q;
        fetch_go   = 1'b0;
        fetch_addr = head_q;
        enter_x    = 1'b0;
        accept     = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    accept = 1'b1;
                    if (list_en && fast) begin
                        st_d       = ST_LOAD;
                        fetch_go   = 1'b1;
                        fetch_addr = head;
                    end else begin
                        st_d    = ST_XFER;
                        enter_x = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (load_done) begin
                    if (hdr_pause) begin
                        st_d = ST_PAUSE;
                    end else begin
                        st_d    = ST_XFER;
                        enter_x = 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (resume) begin
                    st_d    = ST_XFER;
                    enter_x = 1'b1;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    if (list_q && !have_q) begin
                        st_d       = ST_LOAD;
                        fetch_go   = 1'b1;
                        fetch_addr = head_q;
                    end else if (list_q && !hdr_eol) begin
                        st_d       = ST_LOAD;
                        fetch_go   = 1'b1;
                        fetch_addr = next_ptr;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign finish = (st_q == ST_XFER) && (st_d == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            list_q   <= 1'b0;
            have_q   <= 1'b0;
            xs_q     <= 1'b0;
            irq_q    <= 1'b0;
            sticky_q <= 1'b0;
            head_q   <= '0;
            cur_q    <= '0;
        end else begin
            st_q     <= st_d;
            xs_q     <= enter_x;
            irq_q    <= finish;
            sticky_q <= finish | (sticky_q & ~irq_clr);
            if (accept) begin
                list_q <= list_en;
                head_q <= head;
                have_q <= 1'b0;
            end
            if (load_done && (st_q == ST_LOAD)) begin
                have_q <= 1'b1;
            end
            if (fetch_go) begin
                cur_q <= fetch_addr;
            end
        end
    end

    assign xfer_start = xs_q;
    assign state      = st_q;
    assign cur_desc   = cur_q;
    assign prog_ok    = (st_q == ST_IDLE) || (st_q == ST_DONE);
    assign irq        = irq_q;
    assign irq_sticky = sticky_q;

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_start,
    input  logic          ctl_resume,
    input  logic          ctl_fast,
    input  logic          ctl_list_en,
    input  logic [AW-1:0] ctl_head,
    input  logic          ctl_irq_clr,
    input  logic          prog_we,
    input  logic [2:0]    prog_idx,
    input  logic [DW-1:0] prog_data,
    output logic [2:0]    sts_state,
    output logic [AW-1:0] sts_cur_desc,
    output logic          sts_irq_sticky,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    output logic          xfer_start,
    input  logic          xfer_done,
    output logic [DW-1:0] cfg_src,
    output logic [DW-1:0] cfg_dst,
    output logic [DW-1:0] cfg_elem,
    output logic [DW-1:0] cfg_frame,
    output logic [DW-1:0] cfg_ctrl,
    output logic [DW-1:0] cfg_stride,
    output logic          irq
);

    logic                          fetch_go, load_done, hdr_pause, hdr_eol, prog_ok;
    logic [AW-1:0]                 fetch_addr, next_ptr;
    logic                          ld_we;
    logic [WIDX_W-1:0]             ld_idx;
    logic [DW-1:0]                 ld_data;
    logic [NUM_FIELDS-1:0][DW-1:0] fields;
    seq_state_e                    state;

    lldma_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (ctl_start),
        .resume     (ctl_resume),
        .fast       (ctl_fast),
        .list_en    (ctl_list_en),
        .head       (ctl_head),
        .irq_clr    (ctl_irq_clr),
        .xfer_done  (xfer_done),
        .load_done  (load_done),
        .hdr_pause  (hdr_pause),
        .hdr_eol    (hdr_eol),
        .next_ptr   (next_ptr),
        .fetch_go   (fetch_go),
        .fetch_addr (fetch_addr),
        .xfer_start (xfer_start),
        .state      (state),
        .cur_desc   (sts_cur_desc),
        .prog_ok    (prog_ok),
        .irq        (irq),
        .irq_sticky (sts_irq_sticky)
    );

    lldma_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (fetch_go),
        .go_addr   (fetch_addr),
        .req_valid (rd_req_valid),
        .req_ready (rd_req_ready),
        .req_addr  (rd_req_addr),
        .rsp_valid (rd_rsp_valid),
        .rsp_data  (rd_rsp_data),
        .wr_en     (ld_we),
        .wr_idx    (ld_idx),
        .wr_data   (ld_data),
        .load_done (load_done),
        .hdr_pause (hdr_pause),
        .hdr_eol   (hdr_eol),
        .next_ptr  (next_ptr)
    );

    lldma_cfg_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we && prog_ok),
        .prog_idx  (prog_idx),
        .prog_data (prog_data),
        .load_we   (ld_we),
        .load_idx  (ld_idx),
        .load_data (ld_data),
        .fields    (fields)
    );

    assign sts_state  = state;
    assign cfg_src    = fields[0];
    assign cfg_dst    = fields[1];
    assign cfg_elem   = fields[2];
    assign cfg_frame  = fields[3];
    assign cfg_ctrl   = fields[4];
    assign cfg_stride = fields[5];

endmodule

// File: rtl/lldma_seq_chk.sv
module lldma_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_resume,
    input logic [2:0]    sts_state,
    input logic          sts_irq_sticky,
    input logic          rd_req_valid,
    input logic          rd_req_ready,
    input logic          xfer_start,
    input logic          xfer_done,
    input logic [DW-1:0] cfg_src,
    input logic [DW-1:0] cfg_dst,
    input logic [DW-1:0] cfg_elem,
    input logic [DW-1:0] cfg_frame,
    input logic [DW-1:0] cfg_ctrl,
    input logic [DW-1:0] cfg_stride,
    input logic          irq
);

    AST_XSTART_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start); // R12

    AST_XSTART_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> (sts_state == 3'd2)); // R12

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R9

    AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sts_state == 3'd4 && sts_irq_sticky)); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid); // R10

    AST_READ_ONLY_LOADING: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (sts_state == 3'd1)); // R10

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sts_state == 3'd3 && !ctl_resume) |=> (sts_state == 3'd3 && !xfer_start)); // R6

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sts_state == 3'd2 && !xfer_done) |=> (sts_state == 3'd2)); // R7

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (sts_state == 3'd2) |=> ($stable(cfg_src) && $stable(cfg_dst) && $stable(cfg_elem)
                                 && $stable(cfg_frame) && $stable(cfg_ctrl) && $stable(cfg_stride))); // R7

endmodule

bind lldma_seq lldma_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_resume     (ctl_resume),
    .sts_state      (sts_state),
    .sts_irq_sticky (sts_irq_sticky),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .xfer_start     (xfer_start),
    .xfer_done      (xfer_done),
    .cfg_src        (cfg_src),
    .cfg_dst        (cfg_dst),
    .cfg_elem       (cfg_elem),
    .cfg_frame      (cfg_frame),
    .cfg_ctrl       (cfg_ctrl),
    .cfg_stride     (cfg_stride),
    .irq            (irq)
);

// File: tb/tb_lldma_seq.sv
`timescale 1ns/1ps
module tb_lldma_seq;

    localparam int AW  = 16;
    localparam int DW  = 32;
    localparam int LAT = 2;
    localparam int XL  = 8;

    typedef logic [5:0][31:0] cfgv_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_start = 0, ctl_resume = 0, ctl_fast = 0, ctl_list_en = 0, ctl_irq_clr = 0;
    logic [AW-1:0] ctl_head = '0;
    logic          prog_we = 0;
    logic [2:0]    prog_idx = '0;
    logic [DW-1:0] prog_data = '0;
    logic [2:0]    sts_state;
    logic [AW-1:0] sts_cur_desc;
    logic          sts_irq_sticky;
    logic          rd_req_valid, rd_req_ready = 0;
    logic [AW-1:0] rd_req_addr;
    logic          rd_rsp_valid = 0;
    logic [DW-1:0] rd_rsp_data = '0;
    logic          xfer_start, xfer_done = 0;
    logic [DW-1:0] cfg_src, cfg_dst, cfg_elem, cfg_frame, cfg_ctrl, cfg_stride;
    logic          irq;

    always #10 clk = ~clk;

    lldma_seq #(.AW(AW), .DW(DW)) dut (.*);

    logic [31:0] mem [256];
    cfgv_t       model;
    cfgv_t       exp_q[$];
    int          rd_q[$];
    int          n_chk = 0, n_fail = 0;
    int          xfer_cnt = 0, irq_cnt = 0, rd_cnt = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int plen(input int k);
        case (k)
            1: return 6;
            2: return 3;
            3: return 2;
            default: return 0;
        endcase
    endfunction

    // expected transfer configurations and read addresses
    task automatic build_chain(input int head, input bit plain_first);
        int a;
        int k;
        a = head;
        if (plain_first) exp_q.push_back(model);
        for (int n = 0; n < 16; n++) begin
            k = int'(mem[a][1:0]);
            for (int w = 0; w < 2 + plen(k); w++) rd_q.push_back(a + w);
            for (int f = 0; f < plen(k); f++) model[f] = mem[a + 2 + f];
            exp_q.push_back(model);
            if (mem[a][3]) break;
            a = int'(mem[a + 1]);
        end
    endtask

    function automatic cfgv_t got_cfg();
        cfgv_t g;
        g[0] = cfg_src;  g[1] = cfg_dst;  g[2] = cfg_elem;
        g[3] = cfg_frame; g[4] = cfg_ctrl; g[5] = cfg_stride;
        return g;
    endfunction

    // memory responder
    initial begin
        int wait_c = 0;
        int cyc = 0;
        logic [31:0] pdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_rsp_valid = 1'b0;
            if (rst) begin
                wait_c = 0;
            end else if (wait_c > 0) begin
                wait_c--;
                if (wait_c == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = pdata;
                end
            end
            rd_req_ready = (cyc % 4) != 3;
            if (!rst && rd_req_valid && rd_req_ready) begin
                wait_c = LAT;
                pdata  = mem[rd_req_addr[7:0]];
            end
        end
    end

    // transfer datapath responder
    initial begin
        int xc = 0;
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (rst) xc = 0;
            else if (xfer_start) xc = XL;
            else if (xc > 0) begin
                xc--;
                if (xc == 0) xfer_done = 1'b1;
            end
        end
    end

    // reference comparison on every clock
    initial begin
        cfgv_t e;
        int    ea;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (xfer_start) begin
                    xfer_cnt++;
                    if (exp_q.size() == 0) check(0, "R8 unexpected transfer start", 1, 0);
                    else begin
                        e = exp_q.pop_front();
                        check(got_cfg() == e, "R4 R5 config at transfer start", got_cfg(), e);
                    end
                end
                if (irq) begin
                    irq_cnt++;
                    check(exp_q.size() == 0, "R9 irq only after final transfer", exp_q.size(), 0);
                end
                if (rd_req_valid && rd_req_ready) begin
                    rd_cnt++;
                    if (rd_q.size() == 0) check(0, "R10 unexpected read", rd_req_addr, 0);
                    else begin
                        ea = rd_q.pop_front();
                        check(rd_req_addr == AW'(ea), "R10 read address order", rd_req_addr, ea);
                    end
                end
            end
        end
    end

    task automatic do_start(input bit fast, input bit list, input int head);
        @(negedge clk);
        ctl_fast = fast; ctl_list_en = list; ctl_head = AW'(head); ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
    endtask

    task automatic do_prog(input int idx, input logic [31:0] d, input bit upd);
        @(negedge clk);
        prog_we = 1'b1; prog_idx = 3'(idx); prog_data = d;
        if (upd) model[idx] = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk); ctl_resume = 1'b1;
        @(negedge clk); ctl_resume = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); ctl_irq_clr = 1'b1;
        @(negedge clk); ctl_irq_clr = 1'b0;
    endtask

    task automatic wait_state(input logic [2:0] s, input string tag);
        int n;
        n = 0;
        while (sts_state != s && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(sts_state == s, tag, sts_state, s);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL R1 watchdog expired act=hung exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int x0, i0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5000 + i;
        // chain A(16,type1) -> B(40,type3) -> C(64,type2,end)
        mem[16] = 32'h1;  mem[17] = 40;
        mem[40] = 32'h3;  mem[41] = 64;
        mem[64] = 32'hA;  mem[65] = 0;
        // chain D(100,type2) -> E(120,type1,pause,end)
        mem[100] = 32'h2; mem[101] = 120;
        mem[120] = 32'hD; mem[121] = 0;
        model = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sts_state == 3'd0, "R1 reset state idle", sts_state, 0);
        check(!sts_irq_sticky && !irq, "R9 reset irq clear", {sts_irq_sticky, irq}, 0);
        check(!rd_req_valid, "R10 no read at reset", rd_req_valid, 0);
        check(!xfer_start, "R12 no start at reset", xfer_start, 0);
        check(got_cfg() == '0, "R5 reset configuration", got_cfg(), 0);

        // non-fast chain
        for (int f = 0; f < 6; f++) do_prog(f, 32'd100 + 32'(f), 1'b1);
        check(got_cfg() == model, "R7 direct write while idle", got_cfg(), model);
        build_chain(16, 1'b1);
        x0 = xfer_cnt; i0 = irq_cnt;
        do_start(1'b0, 1'b1, 16);
        check(sts_state == 3'd2, "R2 non-fast starts with transfer", sts_state, 2);
        check(rd_cnt == 0, "R2 no read before first transfer", rd_cnt, 0);
        wait_state(3'd4, "R8 chain reaches done");
        check(xfer_cnt - x0 == 4, "R8 transfer count non-fast", xfer_cnt - x0, 4);
        check(irq_cnt - i0 == 1, "R9 single irq", irq_cnt - i0, 1);
        check(sts_irq_sticky, "R9 sticky set", sts_irq_sticky, 1);
        check(sts_cur_desc == 16'd64, "R11 last descriptor address", sts_cur_desc, 64);
        check(rd_q.size() == 0, "R10 all descriptor words read", rd_q.size(), 0);
        pulse_clr();
        check(!sts_irq_sticky, "R9 sticky cleared by write one", sts_irq_sticky, 0);

        // fast chain with pause, commands injected mid-transfer
        build_chain(100, 1'b0);
        x0 = xfer_cnt; i0 = irq_cnt;
        do_start(1'b1, 1'b1, 100);
        check(sts_state == 3'd1, "R3 fast mode loads first", sts_state, 1);
        check(xfer_cnt == x0, "R3 no transfer before load", xfer_cnt - x0, 0);
        wait_state(3'd2, "R3 transfer after load");
        do_start(1'b0, 1'b0, 16);
        check(sts_state == 3'd2 && sts_cur_desc == 16'd100, "R1 start ignored while busy",
              {sts_state, sts_cur_desc}, {3'd2, 16'd100});
        do_prog(0, 32'hDEAD, 1'b0);
        check(cfg_src == model[0] || cfg_src == mem[102], "R7 direct write ignored while busy", cfg_src, mem[102]);
        pulse_resume();
        check(xfer_cnt - x0 == 1, "R6 resume outside pause ignored", xfer_cnt - x0, 1);
        wait_state(3'd3, "R6 pause after load");
        check(sts_cur_desc == 16'd120, "R11 paused descriptor address", sts_cur_desc, 120);
        repeat (10) @(negedge clk);
        check(sts_state == 3'd3 && xfer_cnt - x0 == 1, "R6 paused holds without start",
              {sts_state, 8'(xfer_cnt - x0)}, {3'd3, 8'd1});
        pulse_resume();
        wait_state(3'd4, "R6 resume completes chain");
        check(xfer_cnt - x0 == 2, "R8 transfer count fast", xfer_cnt - x0, 2);
        check(irq_cnt - i0 == 1, "R9 single irq fast", irq_cnt - i0, 1);
        pulse_clr();

        // list mode off, restart from done
        do_prog(3, 32'h77, 1'b1);
        exp_q.push_back(model);
        x0 = xfer_cnt; i0 = irq_cnt; r0 = rd_cnt;
        do_start(1'b1, 1'b0, 16);
        check(sts_state == 3'd2, "R1 start accepted from done", sts_state, 2);
        wait_state(3'd4, "R8 single transfer finishes");
        check(xfer_cnt - x0 == 1, "R8 one transfer without list", xfer_cnt - x0, 1);
        check(rd_cnt == r0, "R8 no memory read without list", rd_cnt - r0, 0);
        check(irq_cnt - i0 == 1, "R9 irq without list", irq_cnt - i0, 1);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule